// File: doc/BRIEF.md
# Codec Control Register Writer with Shadow Bank

This block sits between control logic and a byte-serial bus engine that programs an audio codec. It holds a local shadow of the codec's 24 control registers, each 9 bits wide. Every register write becomes a 16-bit control word: the register address goes in bits 15..9 and the value in the low bits. The word leaves as a two-byte frame over a per-byte valid/ready handshake, high byte first, and carries a fixed target device address. Reads never reach the bus. They are answered from the shadow.

Requests arrive on one port that carries an operation code. A cached write updates the shadow and sends a frame. An uncached send emits a frame and leaves the shadow alone. Three higher-level operations work on top of the shadow. Playback volume maps a 0..128 level onto an attenuation code, does a cached write, then resends the code with the update flag set. Capture gain uses a different offset and sends a single frame. A channel-swap control rewrites the upper nibble of the DAC control register. A higher-level operation whose result equals the shadow sends nothing and reports no change.

Top module: `codec_shadow_writer`

## Requirements
- R1: A frame is the 16-bit word `(addr << 9) | value`, truncated to 16 bits. The high byte goes out first with `txFirst`=1 and the low byte second with `txFirst`=0. `txDev` is always 0x34.
- R2: A cached write or uncached send whose address is above 0x17, or whose value has bit 16 set, is ignored: no frame, no shadow change, and `ackChanged`=0. Any operation code other than 0..4 is ignored the same way.
- R3: `rdData` shows the shadow entry selected by `rdAddr`. Addresses above 0x17 read as 0. Reading produces no bus traffic.
- R4: Operation 0 (cached write) stores `value[8:0]` in the shadow and sends the frame. Operation 1 (uncached send) sends the frame and leaves the shadow unchanged.
- R5: Playback level n maps to code 0 when n is 0 and to n+127 otherwise. `rdPlayLevel` reports code−127 for an 8-bit code above 127 and 0 for any other code.
- R6: Operation 2 (playback volume) targets register 0x03 (`reqRight`=0) or 0x04 (`reqRight`=1). If the new code differs from `shadow[7:0]`, the block does a cached write of the code and then sends a second frame with bit 8 (0x100) set. If the code is equal, the block does nothing.
- R7: Operation 3 (capture gain) targets register 0x0E or 0x0F. Level n maps to 0 when n is 0 and to n+0x4F otherwise, so 128 maps to 0xCF. A different code gives one cached write and no resend. An equal code does nothing. `rdCapLevel` reports code−0x4F for a code above 0x4F and 0 for any other code.
- R8: Operation 4 (swap) sets register 0x07 to `(old & 0x0F) | 0x60` when `value[0]`=1 and to `(old & 0x0F) | 0x90` when `value[0]`=0. It does a cached write only if the result differs from the old value. `chanSwapped` is 1 whenever bits 7..4 of register 0x07 are not 0x9.
- R9: Requests are serialised. `reqReady` stays low from acceptance until every byte of the request has been accepted downstream. A byte that is offered but not accepted stays stable.
- R10: After reset every shadow entry is 0, `reqReady`=1 and `txValid`=0.
- R11: A playback or capture request with a level above 128 is ignored.
- R12: One cycle after each accepted request, `ackValid` pulses. `ackChanged` is 1 exactly when the request produced at least one frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted this cycle when high with reqValid |
| reqOp | input | 3 | 0 write, 1 send, 2 playback, 3 capture, 4 swap |
| reqAddr | input | 8 | Register address for write and send |
| reqRight | input | 1 | Channel select for playback and capture (1 = right) |
| reqValue | input | 17 | Value, level or swap flag (bit 0) |
| ackValid | output | 1 | One-cycle pulse after acceptance |
| ackChanged | output | 1 | Accepted request produced a frame |
| txValid | output | 1 | Byte offered downstream |
| txReady | input | 1 | Downstream takes the byte |
| txFirst | output | 1 | Offered byte is the high byte of a frame |
| txByte | output | 8 | Frame byte |
| txDev | output | 8 | Target device address |
| rdAddr | input | 8 | Shadow read address |
| rdData | output | 9 | Shadow value at rdAddr |
| rdPlayLevel | output | 8 | Playback level decoded from rdData |
| rdCapLevel | output | 8 | Capture level decoded from rdData |
| chanSwapped | output | 1 | Swap state decoded from register 0x07 |

## Verification
The bench repeats playback, capture and swap requests whose result already sits in the shadow. A design that compared all 9 bits, or skipped the comparison, would send frames that are not needed and set `ackChanged`. It checks that the playback resend carries bit 8 while the shadow keeps the value without it. A design that stored the resend value, or sent the two frames in the wrong order, would show it there. It sends an uncached word, a value that uses bits 15..9, and addresses and levels just past their limits. These cases catch a design that wrote the shadow on a send, masked the word wrongly, or accepted 0x18 or level 129. While frames are in flight, `txReady` stalls in a pattern, so a design that dropped a byte, changed it during a stall, or accepted a new request would be caught.

// File: rtl/cw_pkg.sv
package cw_pkg;
  localparam int ByteW = 8;
  localparam int WordW = 2 * ByteW;

  typedef enum logic [2:0] {
    OP_WRITE = 3'd0,
    OP_SEND  = 3'd1,
    OP_PLAY  = 3'd2,
    OP_CAP   = 3'd3,
    OP_SWAP  = 3'd4
  } cw_op_e;

  // control -> datapath strobes
  typedef struct packed {
    logic capture;     // latch frame words and update shadow
    logic takeResend;  // move second word into the output word
    logic selLo;       // present low byte
  } cw_strobe_t;

  // datapath -> control decision for the current request
  typedef struct packed {
    logic frame;
    logic shadowWr;
    logic resend;
  } cw_plan_t;
endpackage

// File: rtl/cw_datapath.sv
module cw_datapath
  import cw_pkg::*;
#(
  parameter int NumRegs  = 24,
  parameter int RegW     = 9,
  parameter int AddrW    = 8,
  parameter int ValW     = 17,
  parameter int CodeW    = 8,
  parameter int MaxLevel = 128,
  parameter int PlayOff  = 127,
  parameter int CapOff   = 79,
  parameter int AddrSh   = 9,
  parameter int PlayLReg = 3,
  parameter int PlayRReg = 4,
  parameter int CapLReg  = 14,
  parameter int CapRReg  = 15,
  parameter int SwapReg  = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       reqOp,
  input  logic [AddrW-1:0] reqAddr,
  input  logic             reqRight,
  input  logic [ValW-1:0]  reqValue,
  input  cw_strobe_t       strb,
  output cw_plan_t         plan,
  output logic [ByteW-1:0] txByte,
  input  logic [AddrW-1:0] rdAddr,
  output logic [RegW-1:0]  rdData,
  output logic [CodeW-1:0] rdPlayLevel,
  output logic [CodeW-1:0] rdCapLevel,
  output logic             chanSwapped
);
  localparam int IdxW = $clog2(NumRegs);
  localparam logic [WordW-1:0] UpdBit = WordW'(1) << (RegW - 1);
  localparam logic [ValW-1:0]  MaxLvlV = ValW'(MaxLevel);
  localparam logic [CodeW-1:0] PlayOffC = CodeW'(PlayOff);
  localparam logic [CodeW-1:0] CapOffC = CodeW'(CapOff);

  logic [RegW-1:0]  shadow [NumRegs];
  logic [AddrW-1:0] tgtAddr;
  logic [IdxW-1:0]  tgtIdx;
  logic [RegW-1:0]  oldVal, newVal, swapVal;
  logic [WordW-1:0] w1, w2, curWord, resendWord;
  logic [CodeW-1:0] lvl, playCode, capCode, rdCode;
  logic             lvlOk, addrOk, valOk;

  function automatic logic [WordW-1:0] mkWord(input logic [AddrW-1:0] a,
                                              input logic [WordW-1:0] v);
    logic [WordW+AddrW-1:0] ext;
    ext = {{WordW{1'b0}}, a} << AddrSh;
    return ext[WordW-1:0] | v;
  endfunction

  always_comb begin
    case (reqOp)
      OP_PLAY: tgtAddr = AddrW'(reqRight ? PlayRReg : PlayLReg);
      OP_CAP:  tgtAddr = AddrW'(reqRight ? CapRReg : CapLReg);
      OP_SWAP: tgtAddr = AddrW'(SwapReg);
      default: tgtAddr = reqAddr;
    endcase
  end

  assign tgtIdx   = tgtAddr[IdxW-1:0];
  assign addrOk   = tgtAddr < AddrW'(NumRegs);
  assign oldVal   = addrOk ? shadow[tgtIdx] : '0;
  assign lvl      = reqValue[CodeW-1:0];
  assign lvlOk    = reqValue <= MaxLvlV;
  assign valOk    = (reqValue >> WordW) == '0;
  assign playCode = (lvl == '0) ? '0 : lvl + PlayOffC;
  assign capCode  = (lvl == '0) ? '0 : lvl + CapOffC;
  assign swapVal  = (oldVal & RegW'(8'h0F)) | RegW'(reqValue[0] ? 8'h60 : 8'h90);

  always_comb begin
    plan   = '0;
    newVal = reqValue[RegW-1:0];
    w1     = mkWord(tgtAddr, reqValue[WordW-1:0]);
    w2     = w1;
    case (reqOp)
      OP_WRITE: if (addrOk && valOk) begin
        plan.frame    = 1'b1;
        plan.shadowWr = 1'b1;
      end
      OP_SEND: if (addrOk && valOk) plan.frame = 1'b1;
      OP_PLAY: begin
        newVal = RegW'(playCode);
        w1     = mkWord(tgtAddr, WordW'(playCode));
        w2     = mkWord(tgtAddr, WordW'(playCode) | UpdBit);
        if (lvlOk && playCode != oldVal[CodeW-1:0]) begin
          plan.frame    = 1'b1;
          plan.shadowWr = 1'b1;
          plan.resend   = 1'b1;
        end
      end
      OP_CAP: begin
        newVal = RegW'(capCode);
        w1     = mkWord(tgtAddr, WordW'(capCode));
        if (lvlOk && capCode != oldVal[CodeW-1:0]) begin
          plan.frame    = 1'b1;
          plan.shadowWr = 1'b1;
        end
      end
      OP_SWAP: begin
        newVal = swapVal;
        w1     = mkWord(tgtAddr, WordW'(swapVal));
        if (swapVal != oldVal) begin
          plan.frame    = 1'b1;
          plan.shadowWr = 1'b1;
        end
      end
      default: plan = '0;
    endcase
  end

  for (genvar i = 0; i < NumRegs; i++) begin : g_shadow
    always_ff @(posedge clk) begin
      if (!rstN) shadow[i] <= '0;
      else if (strb.capture && plan.shadowWr && tgtIdx == IdxW'(i)) shadow[i] <= newVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curWord    <= '0;
      resendWord <= '0;
    end else if (strb.capture) begin
      curWord    <= w1;
      resendWord <= w2;
    end else if (strb.takeResend) begin
      curWord <= resendWord;
    end
  end

  assign txByte = strb.selLo ? curWord[ByteW-1:0] : curWord[WordW-1:ByteW];

  assign rdData      = (rdAddr < AddrW'(NumRegs)) ? shadow[rdAddr[IdxW-1:0]] : '0;
  assign rdCode      = rdData[CodeW-1:0];
  assign rdPlayLevel = (rdCode > PlayOffC) ? rdCode - PlayOffC : '0;
  assign rdCapLevel  = (rdCode > CapOffC) ? rdCode - CapOffC : '0;
  assign chanSwapped = shadow[SwapReg][7:4] != 4'h9;
endmodule

// File: rtl/cw_control.sv
module cw_control
  import cw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  input  cw_plan_t   plan,
  input  logic       txReady,
  output logic       txValid,
  output logic       txFirst,
  output cw_strobe_t strb,
  output logic       ackValid,
  output logic       ackChanged
);
  typedef enum logic [1:0] {S_IDLE, S_HI, S_LO} state_e;
  state_e state;
  logic   resendPend, accept;

  assign reqReady = (state == S_IDLE);
  assign accept   = reqValid && reqReady;
  assign txValid  = (state != S_IDLE);
  assign txFirst  = (state == S_HI);

  always_comb begin
    strb            = '0;
    strb.capture    = accept && plan.frame;
    strb.selLo      = (state == S_LO);
    strb.takeResend = (state == S_LO) && txReady && resendPend;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      resendPend <= 1'b0;
      ackValid   <= 1'b0;
      ackChanged <= 1'b0;
    end else begin
      ackValid   <= accept;
      ackChanged <= accept && plan.frame;
      case (state)
        S_IDLE: if (accept && plan.frame) begin
          state      <= S_HI;
          resendPend <= plan.resend;
        end
        S_HI: if (txReady) state <= S_LO;
        S_LO: if (txReady) begin
          if (resendPend) begin
            state      <= S_HI;
            resendPend <= 1'b0;
          end else begin
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/codec_shadow_writer.sv
module codec_shadow_writer
  import cw_pkg::*;
#(
  parameter int NumRegs = 24,
  parameter int RegW    = 9,
  parameter int AddrW   = 8,
  parameter int ValW    = 17,
  parameter int CodeW   = 8,
  parameter logic [7:0] DevAddr = 8'h34
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [2:0]       reqOp,
  input  logic [AddrW-1:0] reqAddr,
  input  logic             reqRight,
  input  logic [ValW-1:0]  reqValue,
  output logic             ackValid,
  output logic             ackChanged,
  output logic             txValid,
  input  logic             txReady,
  output logic             txFirst,
  output logic [ByteW-1:0] txByte,
  output logic [7:0]       txDev,
  input  logic [AddrW-1:0] rdAddr,
  output logic [RegW-1:0]  rdData,
  output logic [CodeW-1:0] rdPlayLevel,
  output logic [CodeW-1:0] rdCapLevel,
  output logic             chanSwapped
);
  cw_strobe_t strb;
  cw_plan_t   plan;

  assign txDev = DevAddr;

  cw_control uCtl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .plan(plan), .txReady(txReady), .txValid(txValid), .txFirst(txFirst),
    .strb(strb), .ackValid(ackValid), .ackChanged(ackChanged)
  );

  cw_datapath #(
    .NumRegs(NumRegs), .RegW(RegW), .AddrW(AddrW), .ValW(ValW), .CodeW(CodeW)
  ) uDp (
    .clk(clk), .rstN(rstN), .reqOp(reqOp), .reqAddr(reqAddr), .reqRight(reqRight),
    .reqValue(reqValue), .strb(strb), .plan(plan), .txByte(txByte),
    .rdAddr(rdAddr), .rdData(rdData), .rdPlayLevel(rdPlayLevel),
    .rdCapLevel(rdCapLevel), .chanSwapped(chanSwapped)
  );
endmodule

// File: rtl/cw_checker.sv
module cw_checker (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       reqReady,
  input logic       ackValid,
  input logic       txValid,
  input logic       txReady,
  input logic       txFirst,
  input logic [7:0] txByte
);
  // R9
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid && $stable(txByte) && $stable(txFirst));

  // R9
  busy_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !txValid);

  // R12
  ack_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> $past(reqValid && reqReady));

  // R1
  low_after_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid && txReady && txFirst |=> txValid && !txFirst);

  // R1
  high_after_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid && txReady && !txFirst |=> !txValid || txFirst);
endmodule

bind codec_shadow_writer cw_checker uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .ackValid(ackValid), .txValid(txValid), .txReady(txReady),
  .txFirst(txFirst), .txByte(txByte)
);

// File: tb/sim_codec_shadow_writer.sv
module sim_codec_shadow_writer;
  localparam int ClkPeriod = 10;
  localparam int NumVec = 19;

  logic        clk = 1'b0, rstN = 1'b0;
  logic        reqValid = 1'b0, reqRight = 1'b0, txReady = 1'b0;
  logic [2:0]  reqOp = '0;
  logic [7:0]  reqAddr = '0, rdAddr = '0;
  logic [16:0] reqValue = '0;
  logic        reqReady, ackValid, ackChanged, txValid, txFirst, chanSwapped;
  logic [7:0]  txByte, txDev, rdPlayLevel, rdCapLevel;
  logic [8:0]  rdData;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(ClkPeriod / 2) clk = ~clk;

  codec_shadow_writer u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqRight(reqRight), .reqValue(reqValue), .ackValid(ackValid),
    .ackChanged(ackChanged), .txValid(txValid), .txReady(txReady), .txFirst(txFirst),
    .txByte(txByte), .txDev(txDev), .rdAddr(rdAddr), .rdData(rdData),
    .rdPlayLevel(rdPlayLevel), .rdCapLevel(rdCapLevel), .chanSwapped(chanSwapped)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [7:0]  addr;
    logic        right;
    logic [16:0] val;
    logic [1:0]  nFr;
    logic [15:0] w1;
    logic [15:0] w2;
    logic        chg;
    logic [7:0]  chkA;
    logic [8:0]  expRd;
    logic        expSw;
  } vec_t;

  localparam vec_t Vecs [NumVec] = '{
    '{3'd0, 8'h0C, 1'b0, 17'h00022, 2'd1, 16'h1822, 16'h0000, 1'b1, 8'h0C, 9'h022, 1'b1},
    '{3'd1, 8'h03, 1'b0, 17'h001FF, 2'd1, 16'h07FF, 16'h0000, 1'b1, 8'h03, 9'h000, 1'b1},
    '{3'd0, 8'h18, 1'b0, 17'h00005, 2'd0, 16'h0000, 16'h0000, 1'b0, 8'h17, 9'h000, 1'b1},
    '{3'd0, 8'h02, 1'b0, 17'h10000, 2'd0, 16'h0000, 16'h0000, 1'b0, 8'h02, 9'h000, 1'b1},
    '{3'd2, 8'h00, 1'b0, 17'd128,   2'd2, 16'h06FF, 16'h07FF, 1'b1, 8'h03, 9'h0FF, 1'b1},
    '{3'd2, 8'h00, 1'b0, 17'd128,   2'd0, 16'h0000, 16'h0000, 1'b0, 8'h03, 9'h0FF, 1'b1},
    '{3'd2, 8'h00, 1'b1, 17'd1,     2'd2, 16'h0880, 16'h0980, 1'b1, 8'h04, 9'h080, 1'b1},
    '{3'd2, 8'h00, 1'b1, 17'd0,     2'd2, 16'h0800, 16'h0900, 1'b1, 8'h04, 9'h000, 1'b1},
    '{3'd2, 8'h00, 1'b0, 17'd129,   2'd0, 16'h0000, 16'h0000, 1'b0, 8'h03, 9'h0FF, 1'b1},
    '{3'd3, 8'h00, 1'b0, 17'd128,   2'd1, 16'h1CCF, 16'h0000, 1'b1, 8'h0E, 9'h0CF, 1'b1},
    '{3'd3, 8'h00, 1'b1, 17'd1,     2'd1, 16'h1E50, 16'h0000, 1'b1, 8'h0F, 9'h050, 1'b1},
    '{3'd3, 8'h00, 1'b1, 17'd1,     2'd0, 16'h0000, 16'h0000, 1'b0, 8'h0F, 9'h050, 1'b1},
    '{3'd0, 8'h07, 1'b0, 17'h00005, 2'd1, 16'h0E05, 16'h0000, 1'b1, 8'h07, 9'h005, 1'b1},
    '{3'd4, 8'h00, 1'b0, 17'd0,     2'd1, 16'h0E95, 16'h0000, 1'b1, 8'h07, 9'h095, 1'b0},
    '{3'd4, 8'h00, 1'b0, 17'd0,     2'd0, 16'h0000, 16'h0000, 1'b0, 8'h07, 9'h095, 1'b0},
    '{3'd4, 8'h00, 1'b0, 17'd1,     2'd1, 16'h0E65, 16'h0000, 1'b1, 8'h07, 9'h065, 1'b1},
    '{3'd0, 8'h17, 1'b0, 17'h001FF, 2'd1, 16'h2FFF, 16'h0000, 1'b1, 8'h17, 9'h1FF, 1'b1},
    '{3'd0, 8'h00, 1'b0, 17'h0FE00, 2'd1, 16'hFE00, 16'h0000, 1'b1, 8'h00, 9'h000, 1'b1},
    '{3'd7, 8'h00, 1'b0, 17'h00001, 2'd0, 16'h0000, 16'h0000, 1'b0, 8'h00, 9'h000, 1'b1}
  };

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic string tagOf(input logic [2:0] op);
    case (op)
      3'd0, 3'd1: return "R4";
      3'd2:       return "R6";
      3'd3:       return "R7";
      3'd4:       return "R8";
      default:    return "R2";
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] bytes [4];
    logic       firsts [4];
    int         nb;
    bit         busyOk;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(reqReady == 1'b1, "R10", "reqReady after reset", int'(reqReady), 1);
    chk(txValid == 1'b0, "R10", "txValid after reset", int'(txValid), 0);
    for (int a = 0; a < 24; a++) begin
      rdAddr = 8'(a);
      #1;
      chk(rdData == 9'h0, "R10", "shadow after reset", int'(rdData), 0);
    end
    chk(chanSwapped == 1'b1, "R8", "swapped with nibble 0", int'(chanSwapped), 1);
    chk(txDev == 8'h34, "R1", "device address", int'(txDev), 'h34);

    for (int v = 0; v < NumVec; v++) begin
      vec_t t;
      t = Vecs[v];
      reqOp = t.op; reqAddr = t.addr; reqRight = t.right; reqValue = t.val;
      reqValid = 1'b1;
      @(negedge clk);
      reqValid = 1'b0;
      // R12
      chk(ackValid == 1'b1, "R12", "ack pulse", int'(ackValid), 1);
      chk(ackChanged == t.chg, tagOf(t.op), "ackChanged", int'(ackChanged), int'(t.chg));
      nb = 0;
      busyOk = 1'b1;
      for (int c = 0; c < 16; c++) begin
        txReady = (c % 3) != 1;
        #1;
        if (txValid && reqReady) busyOk = 1'b0;
        if (txValid && txReady) begin
          if (nb < 4) begin
            bytes[nb] = txByte;
            firsts[nb] = txFirst;
          end
          nb++;
        end
        @(negedge clk);
      end
      txReady = 1'b0;
      // R9 serialisation
      chk(busyOk, "R9", "ready low while busy", int'(busyOk), 1);
      chk(nb == 2 * int'(t.nFr), tagOf(t.op), "byte count", nb, 2 * int'(t.nFr));
      if (t.nFr >= 1 && nb >= 2) begin
        // R1 byte order and first flag
        chk({bytes[0], bytes[1]} == t.w1, "R1", "frame word", int'({bytes[0], bytes[1]}), int'(t.w1));
        chk(firsts[0] && !firsts[1], "R1", "first flags", int'({firsts[0], firsts[1]}), 2);
      end
      if (t.nFr == 2 && nb >= 4) begin
        chk({bytes[2], bytes[3]} == t.w2, "R6", "resend word", int'({bytes[2], bytes[3]}), int'(t.w2));
        chk(firsts[2] && !firsts[3], "R1", "resend flags", int'({firsts[2], firsts[3]}), 2);
      end
      rdAddr = t.chkA;
      #1;
      chk(rdData == t.expRd, tagOf(t.op), "shadow readback", int'(rdData), int'(t.expRd));
      chk(chanSwapped == t.expSw, "R8", "swap report", int'(chanSwapped), int'(t.expSw));
      // level 129 is vector 9: R11
      if (v == 8) chk(nb == 0, "R11", "level above range", nb, 0);
    end

    // R5 playback readback levels
    rdAddr = 8'h03; #1;
    chk(rdPlayLevel == 8'd128, "R5", "play level code FF", int'(rdPlayLevel), 128);
    rdAddr = 8'h04; #1;
    chk(rdPlayLevel == 8'd0, "R5", "play level code 0", int'(rdPlayLevel), 0);
    rdAddr = 8'h0E; #1;
    chk(rdPlayLevel == 8'd80, "R5", "play level code CF", int'(rdPlayLevel), 80);
    chk(rdCapLevel == 8'd128, "R7", "cap level code CF", int'(rdCapLevel), 128);
    rdAddr = 8'h0F; #1;
    chk(rdCapLevel == 8'd1, "R7", "cap level code 50", int'(rdCapLevel), 1);
    chk(rdPlayLevel == 8'd0, "R5", "play level code 50", int'(rdPlayLevel), 0);
    rdAddr = 8'h0C; #1;
    chk(rdCapLevel == 8'd0, "R7", "cap level code 22", int'(rdCapLevel), 0);

    // R3 reads cause no traffic, out-of-range reads as zero
    busyOk = 1'b1;
    for (int a = 0; a < 32; a++) begin
      rdAddr = 8'(a);
      @(negedge clk);
      if (txValid) busyOk = 1'b0;
    end
    chk(busyOk, "R3", "no traffic on reads", int'(busyOk), 1);
    rdAddr = 8'h18; #1;
    chk(rdData == 9'h0, "R3", "read above range", int'(rdData), 0);
    rdAddr = 8'h17; #1;
    chk(rdData == 9'h1FF, "R3", "read top entry", int'(rdData), 'h1FF);

    // R9 request held off during a stalled frame
    reqOp = 3'd0; reqAddr = 8'h05; reqValue = 17'h011; reqValid = 1'b1;
    @(negedge clk);
    reqAddr = 8'h06; reqValue = 17'h033;
    repeat (3) @(negedge clk);
    chk(reqReady == 1'b0, "R9", "ready during stall", int'(reqReady), 0);
    chk(txByte == 8'h0A && txFirst, "R9", "held high byte", int'(txByte), 'h0A);
    txReady = 1'b1;
    @(negedge clk);
    chk(txByte == 8'h11 && !txFirst, "R9", "low byte", int'(txByte), 'h11);
    @(negedge clk);
    chk(reqReady == 1'b1, "R9", "ready after frame", int'(reqReady), 1);
    @(negedge clk);
    reqValid = 1'b0;
    repeat (3) @(negedge clk);
    txReady = 1'b0;
    rdAddr = 8'h06; #1;
    chk(rdData == 9'h033, "R9", "queued write landed", int'(rdData), 'h33);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule